// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This block carries out a character-draw command that sits in a word-addressed command buffer. It reads a header word, two packed vertex words and two colour words. It then reads eleven glyph words. Each glyph word holds two rows of a 1-bit-per-pixel bitmap that is 16 pixels wide. Every set bit becomes a foreground pixel and every clear bit becomes a background pixel. The pixels are written one per cycle to a framebuffer write port. Each row goes to its own line, starting at the decoded start position.

A pulse on `start` launches a command and `busy` stays high until it ends. A one-cycle `done` pulse marks the end, whether the command was drawn or rejected. The colour depth is chosen with `mode24` when the command starts. The block keeps a dirty box from reset onwards: this is the smallest rectangle that holds every row it has written.

Top module: `glyph_engine`

## Requirements
- R1: A command whose word 0 is not exactly 0x00000a21 ends with a `done` pulse. It writes no pixel and leaves the dirty box unchanged.
- R2: After reset, `busy`, `done`, `fbWe` and `dirtyValid` are low. `start` while idle raises `busy` in the next cycle. `done` is a single-cycle pulse in the last busy cycle. `start` while busy has no effect.
- R3: The start column x is vertex-1 (word 13) bits 29:19, reduced modulo 1280. The end column x2 is the same field of vertex-2 (word 14), reduced the same way. Pixel c of a row is written at column x+c.
- R4: The start line y is ((vertex1 - 63) >> 3) masked to 10 bits, reduced modulo 1024. Row r of the glyph is written at line (y + r) modulo 1024.
- R5: Glyph words are taken from words 4 to 11 and then from words 30 to 32. Each word gives row 2k from bits 15:0 and row 2k+1 from bits 31:16. Within a row, pixel c uses bit c. So bit n of byte 0 is pixel n, and bit n of byte 1 is pixel 8+n. A set bit gives the foreground colour (word 16). A clear bit gives the background colour (word 29).
- R6: Each row has x2-x pixels when x2 > x, and no pixel otherwise. Pixels at index 16 and above are background.
- R7: With `mode24` high, a colour word whose bits 23:16 are 0 gives 0x000000. If those bits are 7 it gives 0xC0C0C0. Any other value gives 0xFFFFFF.
- R8: With `mode24` low, the pixel value is the colour word's bits 7:0, zero-extended to 24 bits.
- R9: After a command, the dirty box holds the minimum x and maximum x2 of every written row, and the minimum and maximum line of every written row, across all commands since reset. `dirtyValid` rises with the first written row. The box does not change while idle.
- R10: An accepted command writes exactly 22 rows, so 22*(x2-x) pixels in total. The pixels of one row go out on consecutive cycles, and `done` follows the last pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a command (ignored while busy) |
| mode24 | input | 1 | 1: 24-bit grey pixels, 0: 8-bit pixels |
| cmdAddr | output | 6 | Command buffer word address |
| cmdData | input | 32 | Command buffer read data, one cycle after the address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| fbWe | output | 1 | Framebuffer pixel write strobe |
| fbX | output | 11 | Pixel column |
| fbY | output | 10 | Pixel line |
| fbData | output | 24 | Pixel value |
| dirtyValid | output | 1 | Dirty box holds at least one row |
| dirtyMinX | output | 11 | Dirty box left column |
| dirtyMinY | output | 10 | Dirty box top line |
| dirtyMaxX | output | 11 | Dirty box right bound (x2 of a row) |
| dirtyMaxY | output | 10 | Dirty box bottom line |

## Verification
The colour assertions assume that `mode24` does not change from the `start` pulse until the `done` pulse. The bench changes it only while the block is idle. They also assume that the command buffer returns data one cycle after the address. The bench models the buffer as a registered array that is never rewritten during a command. It also holds `start` low except for single-cycle pulses, one of which lands deliberately in the middle of a command.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int CmdAw       = 6;
  localparam int XW          = 11;
  localparam int YW          = 10;
  localparam int PixW        = 24;
  localparam int XFieldLsb   = 19;
  localparam int YFieldLsb   = 3;
  localparam logic [31:0] YBias = 32'd63;
  localparam logic [31:0] DrawOpcode = 32'h0000_0a21;

  localparam int Vert1Word   = 13;
  localparam int Vert2Word   = 14;
  localparam int FgWord      = 16;
  localparam int BgWord      = 29;

  localparam int GlyphWords  = 11;
  localparam int GlyphLoBase = 4;
  localparam int GlyphLoCnt  = 8;
  localparam int GlyphHiBase = 30;
  localparam int GlyphRowPix = 16;
  localparam int GlyphIdxW   = $clog2(GlyphWords + 1);
  localparam int RowIdxW     = GlyphIdxW + 1;

  localparam logic [7:0] GreyKeyMid = 8'd7;
  localparam logic [7:0] GreyMid    = 8'hC0;
  localparam logic [7:0] GreyFull   = 8'hFF;

  typedef struct packed {
    logic               launch;
    logic               capV1;
    logic               capV2;
    logic               capFg;
    logic               capBg;
    logic               capGlyph;
    logic               pixWe;
    logic               rowStart;
    logic [RowIdxW-1:0] rowIdx;
    logic [XW-1:0]      col;
  } ctrl_t;
endpackage

// File: rtl/glyph_ctrl.sv
module glyph_ctrl
  import glyph_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             hdrOk,
  input  logic [XW-1:0]    rowWidth,
  output logic [CmdAw-1:0] cmdAddr,
  output logic             busy,
  output logic             done,
  output ctrl_t            ctl
);
  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_V1, S_V2, S_FG, S_BG, S_G0, S_GADDR, S_GCAP, S_PIX, S_FIN
  } state_t;

  state_t               state, stateNext;
  logic [GlyphIdxW-1:0] glyphIdx;
  logic                 rowHalf;
  logic [XW-1:0]        col;
  logic                 rowEnd;
  logic                 lastWord;
  logic                 rowLive;
  logic [CmdAw-1:0]     glyphAddr;

  assign rowLive  = (rowWidth != '0);
  assign rowEnd   = !rowLive || (col == rowWidth - 1'b1);
  assign lastWord = (glyphIdx == GlyphIdxW'(GlyphWords - 1));

  // two separate word ranges hold the glyph
  always_comb begin
    if (glyphIdx < GlyphIdxW'(GlyphLoCnt))
      glyphAddr = CmdAw'(GlyphLoBase) + CmdAw'(glyphIdx);
    else
      glyphAddr = CmdAw'(GlyphHiBase - GlyphLoCnt) + CmdAw'(glyphIdx);
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:  if (start) stateNext = S_HDR;
      S_HDR:   stateNext = S_V1;
      S_V1:    stateNext = hdrOk ? S_V2 : S_FIN;
      S_V2:    stateNext = S_FG;
      S_FG:    stateNext = S_BG;
      S_BG:    stateNext = S_G0;
      S_G0:    stateNext = S_GCAP;
      S_GADDR: stateNext = S_GCAP;
      S_GCAP:  stateNext = S_PIX;
      S_PIX:   if (rowEnd && rowHalf) stateNext = lastWord ? S_FIN : S_GADDR;
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    case (state)
      S_V1:    cmdAddr = CmdAw'(Vert1Word);
      S_V2:    cmdAddr = CmdAw'(Vert2Word);
      S_FG:    cmdAddr = CmdAw'(FgWord);
      S_BG:    cmdAddr = CmdAw'(BgWord);
      S_G0,
      S_GADDR: cmdAddr = glyphAddr;
      default: cmdAddr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      glyphIdx <= '0;
      rowHalf  <= 1'b0;
      col      <= '0;
    end else begin
      state <= stateNext;
      case (state)
        S_IDLE: begin
          glyphIdx <= '0;
          rowHalf  <= 1'b0;
          col      <= '0;
        end
        S_PIX: begin
          if (rowEnd) begin
            col <= '0;
            if (rowHalf) begin
              rowHalf  <= 1'b0;
              glyphIdx <= glyphIdx + 1'b1;
            end else begin
              rowHalf <= 1'b1;
            end
          end else begin
            col <= col + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // data for an address issued in one state is captured in the next
  always_comb begin
    ctl          = '0;
    ctl.launch   = (state == S_IDLE) && start;
    ctl.capV1    = (state == S_V2);
    ctl.capV2    = (state == S_FG);
    ctl.capFg    = (state == S_BG);
    ctl.capBg    = (state == S_G0);
    ctl.capGlyph = (state == S_GCAP);
    ctl.pixWe    = (state == S_PIX) && rowLive;
    ctl.rowStart = ctl.pixWe && (col == '0);
    ctl.rowIdx   = {glyphIdx, rowHalf};
    ctl.col      = col;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
endmodule

// File: rtl/glyph_datapath.sv
module glyph_datapath
  import glyph_pkg::*;
#(
  parameter int FbWidth  = 1280,
  parameter int FbHeight = 1024
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctl,
  input  logic [31:0]     cmdData,
  input  logic            mode24,
  output logic            hdrOk,
  output logic [XW-1:0]   rowWidth,
  output logic            fbWe,
  output logic [XW-1:0]   fbX,
  output logic [YW-1:0]   fbY,
  output logic [PixW-1:0] fbData,
  output logic            dirtyValid,
  output logic [XW-1:0]   dirtyMinX,
  output logic [YW-1:0]   dirtyMinY,
  output logic [XW-1:0]   dirtyMaxX,
  output logic [YW-1:0]   dirtyMaxY
);
  // a single conditional subtract suffices: field range is below twice the limit
  function automatic logic [XW-1:0] wrapX(input logic [XW-1:0] raw);
    logic [XW:0] diff;
    diff = {1'b0, raw} - (XW+1)'(FbWidth);
    return ({1'b0, raw} >= (XW+1)'(FbWidth)) ? diff[XW-1:0] : raw;
  endfunction

  function automatic logic [YW-1:0] wrapY(input logic [YW:0] raw);
    logic [YW:0] diff;
    diff = raw - (YW+1)'(FbHeight);
    return (raw >= (YW+1)'(FbHeight)) ? diff[YW-1:0] : raw[YW-1:0];
  endfunction

  function automatic logic [XW-1:0] decodeX(input logic [31:0] v);
    return wrapX(v[XFieldLsb +: XW]);
  endfunction

  function automatic logic [YW-1:0] decodeY(input logic [31:0] v);
    logic [31:0] unbiased;
    unbiased = v - YBias;
    return wrapY({1'b0, unbiased[YFieldLsb +: YW]});
  endfunction

  function automatic logic [PixW-1:0] shade(input logic [31:0] c, input logic wide);
    if (!wide)                  return {{(PixW-8){1'b0}}, c[7:0]};
    if (c[23:16] == 8'd0)       return '0;
    if (c[23:16] == GreyKeyMid) return {3{GreyMid}};
    return {3{GreyFull}};
  endfunction

  logic            wideReg;
  logic [XW-1:0]   x0Reg, x2Reg;
  logic [YW-1:0]   y0Reg;
  logic [PixW-1:0] fgPix, bgPix;
  logic [31:0]     glyphReg;
  logic [GlyphRowPix-1:0] rowBits;
  logic            bitOn;
  logic [YW-1:0]   rowY;

  assign hdrOk    = (cmdData == DrawOpcode);
  assign rowWidth = (x2Reg > x0Reg) ? (x2Reg - x0Reg) : '0;
  assign rowBits  = ctl.rowIdx[0] ? glyphReg[31:16] : glyphReg[15:0];
  assign bitOn    = (ctl.col < XW'(GlyphRowPix)) && rowBits[ctl.col[3:0]];
  assign rowY     = wrapY({1'b0, y0Reg} + (YW+1)'(ctl.rowIdx));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideReg  <= 1'b0;
      x0Reg    <= '0;
      x2Reg    <= '0;
      y0Reg    <= '0;
      fgPix    <= '0;
      bgPix    <= '0;
      glyphReg <= '0;
    end else begin
      if (ctl.launch)   wideReg  <= mode24;
      if (ctl.capV1) begin
        x0Reg <= decodeX(cmdData);
        y0Reg <= decodeY(cmdData);
      end
      if (ctl.capV2)    x2Reg    <= decodeX(cmdData);
      if (ctl.capFg)    fgPix    <= shade(cmdData, wideReg);
      if (ctl.capBg)    bgPix    <= shade(cmdData, wideReg);
      if (ctl.capGlyph) glyphReg <= cmdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbWe   <= 1'b0;
      fbX    <= '0;
      fbY    <= '0;
      fbData <= '0;
    end else begin
      fbWe   <= ctl.pixWe;
      fbX    <= x0Reg + ctl.col;
      fbY    <= rowY;
      fbData <= bitOn ? fgPix : bgPix;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirtyValid <= 1'b0;
      dirtyMinX  <= '0;
      dirtyMaxX  <= '0;
      dirtyMinY  <= '0;
      dirtyMaxY  <= '0;
    end else if (ctl.rowStart) begin
      dirtyValid <= 1'b1;
      if (!dirtyValid || x0Reg < dirtyMinX) dirtyMinX <= x0Reg;
      if (!dirtyValid || x2Reg > dirtyMaxX) dirtyMaxX <= x2Reg;
      if (!dirtyValid || rowY < dirtyMinY)  dirtyMinY <= rowY;
      if (!dirtyValid || rowY > dirtyMaxY)  dirtyMaxY <= rowY;
    end
  end
endmodule

// File: rtl/glyph_engine.sv
module glyph_engine
  import glyph_pkg::*;
#(
  parameter int FbWidth  = 1280,
  parameter int FbHeight = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             mode24,
  output logic [CmdAw-1:0] cmdAddr,
  input  logic [31:0]      cmdData,
  output logic             busy,
  output logic             done,
  output logic             fbWe,
  output logic [XW-1:0]    fbX,
  output logic [YW-1:0]    fbY,
  output logic [PixW-1:0]  fbData,
  output logic             dirtyValid,
  output logic [XW-1:0]    dirtyMinX,
  output logic [YW-1:0]    dirtyMinY,
  output logic [XW-1:0]    dirtyMaxX,
  output logic [YW-1:0]    dirtyMaxY
);
  ctrl_t         ctl;
  logic          hdrOk;
  logic [XW-1:0] rowWidth;

  glyph_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .hdrOk    (hdrOk),
    .rowWidth (rowWidth),
    .cmdAddr  (cmdAddr),
    .busy     (busy),
    .done     (done),
    .ctl      (ctl)
  );

  glyph_datapath #(.FbWidth(FbWidth), .FbHeight(FbHeight)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdData    (cmdData),
    .mode24     (mode24),
    .hdrOk      (hdrOk),
    .rowWidth   (rowWidth),
    .fbWe       (fbWe),
    .fbX        (fbX),
    .fbY        (fbY),
    .fbData     (fbData),
    .dirtyValid (dirtyValid),
    .dirtyMinX  (dirtyMinX),
    .dirtyMinY  (dirtyMinY),
    .dirtyMaxX  (dirtyMaxX),
    .dirtyMaxY  (dirtyMaxY)
  );
endmodule

// File: rtl/glyph_engine_chk.sv
module glyph_engine_chk
  import glyph_pkg::*;
#(
  parameter int FbWidth = 1280
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            mode24,
  input logic            busy,
  input logic            done,
  input logic            fbWe,
  input logic [XW-1:0]   fbX,
  input logic [PixW-1:0] fbData,
  input logic            dirtyValid,
  input logic [XW-1:0]   dirtyMinX,
  input logic [YW-1:0]   dirtyMinY,
  input logic [XW-1:0]   dirtyMaxX,
  input logic [YW-1:0]   dirtyMaxY
);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  p_start_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  p_busy_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  p_write_in_cmd_r10: assert property (@(posedge clk) disable iff (!rstN)
    fbWe |-> busy);
  p_col_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    fbWe |-> (fbX < XW'(FbWidth)));
  p_grey_levels_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fbWe && mode24) |->
      (fbData == 24'h000000 || fbData == 24'hC0C0C0 || fbData == 24'hFFFFFF));
  p_narrow_pixel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fbWe && !mode24) |-> (fbData[PixW-1:8] == '0));
  p_box_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    dirtyValid |-> (dirtyMinX < dirtyMaxX && dirtyMinY <= dirtyMaxY));
  p_box_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(dirtyValid) && $stable(dirtyMinX) && $stable(dirtyMaxX)
               && $stable(dirtyMinY) && $stable(dirtyMaxY)));
endmodule

bind glyph_engine glyph_engine_chk #(.FbWidth(FbWidth)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .mode24     (mode24),
  .busy       (busy),
  .done       (done),
  .fbWe       (fbWe),
  .fbX        (fbX),
  .fbData     (fbData),
  .dirtyValid (dirtyValid),
  .dirtyMinX  (dirtyMinX),
  .dirtyMinY  (dirtyMinY),
  .dirtyMaxX  (dirtyMaxX),
  .dirtyMaxY  (dirtyMaxY)
);

// File: tb/tb_glyph_engine.sv
`timescale 1ns/100ps
module tb_glyph_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        mode24 = 1'b0;
  logic [5:0]  cmdAddr;
  logic [31:0] cmdData;
  logic        busy, done, fbWe, dirtyValid;
  logic [10:0] fbX, dirtyMinX, dirtyMaxX;
  logic [9:0]  fbY, dirtyMinY, dirtyMaxY;
  logic [23:0] fbData;

  logic [31:0] cmdMem [64];
  int checks = 0;
  int errors = 0;

  // expected-state of the current command
  int          expX, expY, expX2, expW, wrCount;
  logic [23:0] expFg, expBg;
  logic [31:0] expGlyph [11];
  bit          expM24;
  // dirty box model
  bit mValid = 0;
  int mMinX, mMaxX, mMinY, mMaxY;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) cmdData <= cmdMem[cmdAddr];

  glyph_engine dut (
    .clk(clk), .rstN(rstN), .start(start), .mode24(mode24),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .busy(busy), .done(done),
    .fbWe(fbWe), .fbX(fbX), .fbY(fbY), .fbData(fbData),
    .dirtyValid(dirtyValid), .dirtyMinX(dirtyMinX), .dirtyMinY(dirtyMinY),
    .dirtyMaxX(dirtyMaxX), .dirtyMaxY(dirtyMaxY)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] greyOf(input logic [31:0] c, input bit m24);
    if (!m24) return {16'h0, c[7:0]};
    if (((c >> 16) & 32'hFF) == 0) return 24'h000000;
    if (((c >> 16) & 32'hFF) == 7) return 24'hC0C0C0;
    return 24'hFFFFFF;
  endfunction

  function automatic int colOf(input logic [31:0] v);
    return int'((v >> 19) & 32'd2047) % 1280;
  endfunction

  function automatic int lineOf(input logic [31:0] v);
    logic [31:0] t;
    t = v - 32'd63;
    return int'((t >> 3) & 32'd1023) % 1024;
  endfunction

  function automatic logic [31:0] mkV(input int x, input int y);
    return (32'(x) << 19) | 32'(y * 8 + 63);
  endfunction

  // pixel monitor: compares every write with the model
  always @(negedge clk) begin
    if (rstN && fbWe) begin
      int r, c, ey;
      logic [15:0] bits;
      logic [23:0] ed;
      bit on;
      if (expW == 0) begin
        check(1'b0, "R1/R6", "write when none expected", wrCount, 0);
      end else begin
        r = wrCount / expW;
        c = wrCount % expW;
        if (r >= 22) begin
          check(1'b0, "R10", "write beyond row 22", r, 21);
        end else begin
          ey   = (expY + r) % 1024;
          bits = (r % 2 == 1) ? expGlyph[r/2][31:16] : expGlyph[r/2][15:0];
          on   = (c < 16) && bits[c];
          ed   = on ? expFg : expBg;
          check(fbX == 11'(expX + c), "R3", "pixel column", fbX, expX + c);
          check(fbY == 10'(ey), "R4", "pixel line", fbY, ey);
          check(fbData == ed, (c >= 16) ? "R6" : (expM24 ? "R5/R7" : "R5/R8"),
                "pixel value", fbData, ed);
        end
      end
      wrCount++;
    end
  end

  task automatic runCmd(input bit m24, input bit good, input logic [31:0] v1,
                        input logic [31:0] v2, input logic [31:0] fg,
                        input logic [31:0] bg, input int seed, input bit midStart);
    for (int i = 0; i < 64; i++) cmdMem[i] = 32'hA5A5_0000 | 32'(i);
    cmdMem[0]  = good ? 32'h0000_0a21 : (32'h0000_0a21 ^ 32'(1 << (seed % 12)));
    cmdMem[13] = v1;
    cmdMem[14] = v2;
    cmdMem[16] = fg;
    cmdMem[29] = bg;
    for (int k = 0; k < 11; k++) begin
      logic [31:0] gw;
      gw = (32'h9E37_79B9 * 32'(seed * 11 + k + 1)) ^ (32'h0000_FFFF << (k % 17));
      expGlyph[k] = gw;
      if (k < 8) cmdMem[4 + k] = gw;
      else       cmdMem[30 + k - 8] = gw;
    end
    expM24 = m24;
    expX   = colOf(v1);
    expY   = lineOf(v1);
    expX2  = colOf(v2);
    expW   = good ? ((expX2 > expX) ? expX2 - expX : 0) : 0;
    expFg  = greyOf(fg, m24);
    expBg  = greyOf(bg, m24);
    wrCount = 0;
    if (expW > 0) begin
      for (int r = 0; r < 22; r++) begin
        int ly;
        ly = (expY + r) % 1024;
        if (!mValid) begin
          mMinX = expX; mMaxX = expX2; mMinY = ly; mMaxY = ly; mValid = 1;
        end else begin
          if (expX < mMinX)  mMinX = expX;
          if (expX2 > mMaxX) mMaxX = expX2;
          if (ly < mMinY)    mMinY = ly;
          if (ly > mMaxY)    mMaxY = ly;
        end
      end
    end

    @(negedge clk);
    mode24 = m24;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (midStart) begin
      repeat (30) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R2", "done single pulse", done, 0);
    check(busy == 1'b0, "R2", "idle after done", busy, 0);
    check(wrCount == 22 * expW, good ? "R10" : "R1", "pixel count", wrCount, 22 * expW);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R2", "no restart from start while busy", busy, 0);
    check(dirtyValid == mValid, "R9", "dirty valid", dirtyValid, mValid);
    if (mValid) begin
      check(dirtyMinX == 11'(mMinX), "R9", "dirty min x", dirtyMinX, mMinX);
      check(dirtyMaxX == 11'(mMaxX), "R9", "dirty max x", dirtyMaxX, mMaxX);
      check(dirtyMinY == 10'(mMinY), "R9", "dirty min y", dirtyMinY, mMinY);
      check(dirtyMaxY == 10'(mMaxY), "R9", "dirty max y", dirtyMaxY, mMaxY);
    end
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) cmdMem[i] = '0;
    expW = 0; wrCount = 0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R2", "reset handshake", {busy, done}, 0);
    check(fbWe == 1'b0, "R2", "reset write strobe", fbWe, 0);
    check(dirtyValid == 1'b0, "R2", "reset dirty valid", dirtyValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: rejected header, nothing drawn, box stays empty
    runCmd(1'b1, 1'b0, mkV(100, 50), mkV(116, 60), 32'h0007_0000, 32'h0, 3, 1'b0);
    // R5/R7: full 16-pixel rows, grey levels
    runCmd(1'b1, 1'b1, mkV(100, 50), mkV(116, 60), 32'h0007_0000, 32'h0, 1, 1'b0);
    runCmd(1'b1, 1'b1, mkV(200, 300), mkV(208, 0), 32'h00FF_00AA, 32'h0007_1234, 2, 1'b0);
    // R6/R8: row wider than the glyph, 8-bit colours
    runCmd(1'b0, 1'b1, mkV(40, 10), mkV(60, 0), 32'h1234_56AB, 32'hFFFF_FF5C, 4, 1'b0);
    // R6: zero width
    runCmd(1'b1, 1'b1, mkV(500, 20), mkV(400, 0), 32'h0001_0000, 32'h0, 5, 1'b0);
    // R4: line wrap at the bottom
    runCmd(1'b1, 1'b1, mkV(600, 1015), mkV(612, 0), 32'h0000_00FF, 32'h0007_0000, 6, 1'b0);
    // R3: column field at and above 1280 reduces modulo
    runCmd(1'b0, 1'b1, mkV(1290, 5), mkV(1300, 5), 32'h0000_0011, 32'h0000_0022, 7, 1'b0);
    // R4: vertex low bits below the bias borrow into the x field
    runCmd(1'b1, 1'b1, (32'd700 << 19) | 32'd5, mkV(716, 0), 32'h0003_0000, 32'h0, 8, 1'b0);
    // R2: start pulse in the middle of a command
    runCmd(1'b0, 1'b1, mkV(10, 900), mkV(26, 0), 32'h0000_0080, 32'h0000_0001, 9, 1'b1);
    // sweep of widths, positions and modes
    for (int s = 0; s < 16; s++) begin
      runCmd(s[0], 1'b1, mkV(64 * s + 3, 37 * s), mkV(64 * s + 3 + s + 1, 0),
             32'(s * 32'h0001_0003), 32'(((s + 7) % 9) << 16 | s), 20 + s, 1'b0);
    end
    // R1 again after drawing: box untouched
    runCmd(1'b0, 1'b0, mkV(0, 0), mkV(16, 0), 32'h0, 32'h0, 11, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule